// File: doc/BRIEF.md
# Pin Event Router

This block lets each of eight general-purpose pins serve as a trigger source for internal control resources. A 3-bit route code per pin sends the pin's sensed level to one of two counter clock inputs, or turns its edges into requests on one of two interrupt lines. The high-priority line and the low-priority line can each be reached through a rising-edge code and a falling-edge code. When several pins choose the same resource, their contributions are merged with a logical OR.

The level that is sensed always comes from the pad, never from the output register. A pin that drives pulses out can therefore still count those pulses. The block also builds the pad output and output-enable vectors.

- Pins 6 and 7 can be handed to an external pulse engine as a strobe output and a fault-pulse output, but only while they are set as outputs.
- Pins 4 and 5 can be handed over as a whole to a serial EEPROM engine.

Top module: `pin_event_router`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `cnt0_clk`, `cnt1_clk`, `irq_hi`, `irq_lo`, `pad_oe` and `pad_out` are all 0, whatever the inputs are.
- R2: Route codes 0 and 1 (the reserved value) drive no resource. With every pin on one of these codes, the counter clocks stay at 0 and no interrupt pulse appears, whatever the pads do.
- R3: Code 2 connects the pin to `cnt0_clk` and code 3 connects it to `cnt1_clk`. The output follows the pad level. A change driven on the pad before clock edge k shows at the output after edge k+2.
- R4: Code 4 (high) and code 5 (low) give exactly one single-cycle pulse on `irq_hi` or `irq_lo` for each rising pad edge. A falling edge gives none.
- R5: Code 6 (high) and code 7 (low) give exactly one single-cycle pulse on `irq_hi` or `irq_lo` for each falling pad edge. A rising edge gives none.
- R6: Pins that share a resource are OR-merged. A counter clock stays high while any of its pins is high. Qualifying edges that occur in the same cycle on several pins give a single pulse.
- R7: Routing senses `pad_in` no matter what the direction bit says. A pin that is set as an output still triggers its route.
- R8: Without an override, `pad_oe[i]` equals `pin_dir[i]` (1 = output), one cycle after the inputs. `pad_out[i]` equals `pin_dout[i]` when the pin is an output and 0 when it is an input.
- R9: When `strobe_en` is set and pin 6 is an output, `pad_out[6]` follows `strobe_pulse`. The same holds for `fault_en`, pin 7 and `fault_pulse`. An enable on a pin set as input leaves that pin undriven (oe 0, out 0).
- R10: When `eeprom_en` is set, pins 4 and 5 take their enable from `ee_oe[1:0]` and their value from `ee_out[1:0]` (bit 0 goes to pin 4), whatever their direction bits say. The value is gated to 0 where the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | 8 | Level sensed at each pad |
| pin_dir | input | 8 | Direction per pin, 1 = output |
| pin_dout | input | 8 | Output data per pin |
| route_sel | input | 24 | Route code per pin, pin i in bits [3i+2:3i] |
| strobe_en | input | 1 | Hand pin 6 to the strobe pulse |
| fault_en | input | 1 | Hand pin 7 to the fault pulse |
| eeprom_en | input | 1 | Hand pins 4 and 5 to the EEPROM engine |
| strobe_pulse | input | 1 | Strobe from the pulse engine |
| fault_pulse | input | 1 | Fault pulse from the pulse engine |
| ee_out | input | 2 | EEPROM engine data for pins 5:4 |
| ee_oe | input | 2 | EEPROM engine enables for pins 5:4 |
| pad_out | output | 8 | Registered pad drive value |
| pad_oe | output | 8 | Registered pad output enable |
| cnt0_clk | output | 1 | Counter 0 clock source |
| cnt1_clk | output | 1 | Counter 1 clock source |
| irq_hi | output | 1 | High-priority interrupt request pulse |
| irq_lo | output | 1 | Low-priority interrupt request pulse |

## Verification
The hardest case to reach is OR-merging of edges that arrive on two pins in the same clock cycle. There the design must give one pulse and not two, and a simple per-pin sweep never produces that. The bench drives two pins that share a route in the same cycle and counts the pulses it sees.

The bench also sweeps every pin through all eight route codes with a full rise and fall. It checks counter levels and pulse counts against values derived from the code.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;
  typedef enum logic [2:0] {
    RT_NONE  = 3'd0,
    RT_RSVD  = 3'd1,
    RT_CNT0  = 3'd2,
    RT_CNT1  = 3'd3,
    RT_HI_RE = 3'd4,
    RT_LO_RE = 3'd5,
    RT_HI_FE = 3'd6,
    RT_LO_FE = 3'd7
  } route_code_e;

  typedef struct packed {
    logic lo;
    logic hi;
    logic c1;
    logic c0;
  } route_hit_t;

  localparam int SEL_W      = 3;
  localparam int STROBE_PIN = 6;
  localparam int FAULT_PIN  = 7;
  localparam int EE_PIN0    = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], raw};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/route_decode.sv
module route_decode
  import pin_route_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  output route_hit_t       hit
);
  route_code_e code;
  assign code = route_code_e'(sel);

  always_comb begin
    hit = '0;
    unique case (code)
      RT_CNT0:  hit.c0 = lvl;
      RT_CNT1:  hit.c1 = lvl;
      RT_HI_RE: hit.hi = rise;
      RT_LO_RE: hit.lo = rise;
      RT_HI_FE: hit.hi = fall;
      RT_LO_FE: hit.lo = fall;
      default:  hit = '0;
    endcase
  end
endmodule

// File: rtl/pad_driver.sv
module pad_driver
  import pin_route_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_dir,
  input  logic [NPINS-1:0] pin_dout,
  input  logic             strobe_en,
  input  logic             fault_en,
  input  logic             eeprom_en,
  input  logic             strobe_pulse,
  input  logic             fault_pulse,
  input  logic [1:0]       ee_out,
  input  logic [1:0]       ee_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic [NPINS-1:0] val_n, oe_n;

  always_comb begin
    oe_n  = pin_dir;
    val_n = pin_dout;
    if (strobe_en) val_n[STROBE_PIN] = strobe_pulse;
    if (fault_en)  val_n[FAULT_PIN]  = fault_pulse;
    if (eeprom_en) begin
      oe_n[EE_PIN0+1:EE_PIN0]  = ee_oe;
      val_n[EE_PIN0+1:EE_PIN0] = ee_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_oe  <= oe_n;
      pad_out <= val_n & oe_n;
    end
  end

  assert_oe_dir_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_oe[0] == $past(pin_dir[0]));

  assert_input_undriven_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pin_dir[STROBE_PIN])) |-> !pad_oe[STROBE_PIN] && !pad_out[STROBE_PIN]);

  assert_ee_takeover_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(eeprom_en)) |-> pad_oe[EE_PIN0] == $past(ee_oe[0]));
endmodule

// File: rtl/pin_event_router.sv
module pin_event_router
  import pin_route_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       pad_in,
  input  logic [NPINS-1:0]       pin_dir,
  input  logic [NPINS-1:0]       pin_dout,
  input  logic [NPINS*SEL_W-1:0] route_sel,
  input  logic                   strobe_en,
  input  logic                   fault_en,
  input  logic                   eeprom_en,
  input  logic                   strobe_pulse,
  input  logic                   fault_pulse,
  input  logic [1:0]             ee_out,
  input  logic [1:0]             ee_oe,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  output logic                   cnt0_clk,
  output logic                   cnt1_clk,
  output logic                   irq_hi,
  output logic                   irq_lo
);
  route_hit_t hits [NPINS];
  route_hit_t merged;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic lvl, rise, fall;
    pin_sync #(.STAGES(2)) i_sync (
      .clk(clk), .rst(rst), .raw(pad_in[g]),
      .lvl(lvl), .rise(rise), .fall(fall));
    route_decode i_dec (
      .sel(route_sel[g*SEL_W +: SEL_W]), .lvl(lvl),
      .rise(rise), .fall(fall), .hit(hits[g]));
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NPINS; i++) merged = merged | hits[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt0_clk <= 1'b0;
      cnt1_clk <= 1'b0;
      irq_hi   <= 1'b0;
      irq_lo   <= 1'b0;
    end else begin
      cnt0_clk <= merged.c0;
      cnt1_clk <= merged.c1;
      irq_hi   <= merged.hi;
      irq_lo   <= merged.lo;
    end
  end

  pad_driver #(.NPINS(NPINS)) i_pads (
    .clk(clk), .rst(rst), .pin_dir(pin_dir), .pin_dout(pin_dout),
    .strobe_en(strobe_en), .fault_en(fault_en), .eeprom_en(eeprom_en),
    .strobe_pulse(strobe_pulse), .fault_pulse(fault_pulse),
    .ee_out(ee_out), .ee_oe(ee_oe), .pad_out(pad_out), .pad_oe(pad_oe));

  // Selector-side view used only by the checks below
  logic hi_routed, lo_routed, none_routed;
  always_comb begin
    hi_routed   = 1'b0;
    lo_routed   = 1'b0;
    none_routed = 1'b1;
    for (int i = 0; i < NPINS; i++) begin
      if (route_sel[i*SEL_W +: SEL_W] inside {3'd4, 3'd6}) hi_routed = 1'b1;
      if (route_sel[i*SEL_W +: SEL_W] inside {3'd5, 3'd7}) lo_routed = 1'b1;
      if (route_sel[i*SEL_W +: SEL_W] > 3'd1) none_routed = 1'b0;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_hi && !irq_lo && !cnt0_clk && !cnt1_clk && pad_oe == '0);

  assert_hi_needs_route_R4: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(hi_routed));

  assert_lo_needs_route_R5: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> $past(lo_routed));

  assert_unrouted_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(none_routed)) |-> !irq_hi && !irq_lo && !cnt0_clk && !cnt1_clk);
endmodule

// File: tb/test_pin_event_router.sv
module test_pin_event_router;
  localparam int N = 8;
  logic clk = 0, rst = 1;
  logic [N-1:0] pad_in = '0, pin_dir = '0, pin_dout = '0;
  logic [N*3-1:0] route_sel = '0;
  logic strobe_en = 0, fault_en = 0, eeprom_en = 0, strobe_pulse = 0, fault_pulse = 0;
  logic [1:0] ee_out = '0, ee_oe = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic cnt0_clk, cnt1_clk, irq_hi, irq_lo;
  int checks = 0, fails = 0, hi_tot = 0, lo_tot = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_event_router #(.NPINS(N)) i_pin_event_router (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pin_dir(pin_dir), .pin_dout(pin_dout),
    .route_sel(route_sel), .strobe_en(strobe_en), .fault_en(fault_en),
    .eeprom_en(eeprom_en), .strobe_pulse(strobe_pulse), .fault_pulse(fault_pulse),
    .ee_out(ee_out), .ee_oe(ee_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .cnt0_clk(cnt0_clk), .cnt1_clk(cnt1_clk), .irq_hi(irq_hi), .irq_lo(irq_lo));

  always @(negedge clk) begin
    if (irq_hi) hi_tot++;
    if (irq_lo) lo_tot++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string tag(int code);
    if (code < 2) return "R2";
    if (code < 4) return "R3";
    if (code < 6) return "R4";
    return "R5";
  endfunction

  initial begin
    int h0, l0;
    // R1: hostile inputs while reset is high
    pad_in = '1; pin_dir = '1; pin_dout = '1; route_sel = {N{3'd4}};
    cyc(3);
    chk("R1", {cnt0_clk, cnt1_clk, irq_hi, irq_lo}, 0);
    chk("R1", {pad_oe, pad_out}, 0);
    pad_in = '0; pin_dir = '0; pin_dout = '0; route_sel = '0;
    rst = 0;
    cyc(1);
    chk("R1", {pad_oe, pad_out, cnt0_clk, cnt1_clk, irq_hi, irq_lo}, 0);

    // Sweep: every pin through every route code, R2..R5
    for (int p = 0; p < N; p++) begin
      for (int code = 0; code < 8; code++) begin
        route_sel = '0;
        route_sel[p*3 +: 3] = 3'(code);
        cyc(5);
        h0 = hi_tot; l0 = lo_tot;
        pad_in[p] = 1'b1;
        cyc(5);
        chk(tag(code), {cnt1_clk, cnt0_clk}, {code == 3, code == 2});
        chk(tag(code), hi_tot - h0, code == 4);
        chk(tag(code), lo_tot - l0, code == 5);
        pad_in[p] = 1'b0;
        cyc(5);
        chk(tag(code), {cnt1_clk, cnt0_clk}, 0);
        chk(tag(code), hi_tot - h0, (code == 4) + (code == 6));
        chk(tag(code), lo_tot - l0, (code == 5) + (code == 7));
      end
    end

    // R3 latency: visible after the third edge, not the second
    route_sel = '0; route_sel[0 +: 3] = 3'd2; cyc(4);
    pad_in[0] = 1'b1;
    cyc(2); chk("R3", cnt0_clk, 0);
    cyc(1); chk("R3", cnt0_clk, 1);
    pad_in[0] = 1'b0; cyc(4);

    // R6: OR of levels, and one pulse for edges in the same cycle
    route_sel = '0; route_sel[1*3 +: 3] = 3'd2; route_sel[3*3 +: 3] = 3'd2; cyc(4);
    pad_in[1] = 1; cyc(4); pad_in[3] = 1; cyc(4); pad_in[1] = 0; cyc(4);
    chk("R6", cnt0_clk, 1);
    pad_in[3] = 0; cyc(4);
    chk("R6", cnt0_clk, 0);
    route_sel = '0; route_sel[0 +: 3] = 3'd4; route_sel[2*3 +: 3] = 3'd4; cyc(4);
    h0 = hi_tot;
    pad_in[0] = 1; pad_in[2] = 1; cyc(6);
    chk("R6", hi_tot - h0, 1);
    pad_in[0] = 0; pad_in[2] = 0; cyc(4);

    // R7: pin set as output still triggers its route from the pad
    pin_dir = '1; pin_dout = '0;
    route_sel = '0; route_sel[2*3 +: 3] = 3'd5; cyc(4);
    l0 = lo_tot;
    pad_in[2] = 1; cyc(6);
    chk("R7", lo_tot - l0, 1);
    pad_in[2] = 0; route_sel = '0; cyc(4);

    // R8: normal direction/data patterns
    for (int k = 0; k < 16; k++) begin
      pin_dir = 8'(k * 37 + 5); pin_dout = 8'(k * 91 + 3);
      cyc(1);
      chk("R8", pad_oe, pin_dir);
      chk("R8", pad_out, pin_dir & pin_dout);
    end

    // R9: strobe and fault overrides
    pin_dir = 8'hC0; pin_dout = 8'h00; strobe_en = 1; fault_en = 1;
    strobe_pulse = 1; fault_pulse = 0; cyc(1);
    chk("R9", pad_out[7:6], 2'b01);
    strobe_pulse = 0; fault_pulse = 1; cyc(1);
    chk("R9", pad_out[7:6], 2'b10);
    pin_dir = 8'h00; strobe_pulse = 1; cyc(1);
    chk("R9", {pad_oe[7:6], pad_out[7:6]}, 0);
    strobe_en = 0; fault_en = 0; strobe_pulse = 0; fault_pulse = 0;

    // R10: EEPROM takeover of pins 4 and 5
    pin_dir = 8'h00; pin_dout = 8'hFF; eeprom_en = 1; ee_oe = 2'b11; ee_out = 2'b01; cyc(1);
    chk("R10", {pad_oe[5:4], pad_out[5:4]}, 4'b1101);
    pin_dir = 8'hFF; ee_oe = 2'b10; ee_out = 2'b01; cyc(1);
    chk("R10", {pad_oe[5:4], pad_out[5:4]}, 4'b1000);
    eeprom_en = 0; cyc(1);
    chk("R10", {pad_oe[5:4], pad_out[5:4]}, 4'b1111);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule